// File: doc/BRIEF.md
# Preemptive DMA Channel Arbiter

This block decides which of up to sixteen DMA channels the transfer engine serves next. Each channel presents a request bit, a 4-bit priority, a flag saying it may be interrupted and a flag saying it may interrupt others. When the engine is idle the arbiter starts one requesting channel, chosen either by highest priority or by a rotating search. A channel that is running can be set aside for a more urgent one, and a channel whose minor loop links back to itself can be kept running without going back through arbitration.

The engine reports when it is in the middle of a bus access and when the active channel's minor loop has finished. The arbiter holds the granted channel until that completion pulse. A priority checker raises an error whenever two channels share a priority. A debug stall input, honoured only when debug mode is on, freezes all new starts while letting the running channel complete. The data movement itself is handled elsewhere.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset the grant is inactive, the preempt strobe and priority error are low, and `mode_o` reads 4'b0010 (bit 0 round robin, bit 1 halt on error, bit 2 continuous link, bit 3 debug).
- R2: A cycle with `mode_we_i` high loads `mode_wdata_i` into the mode, which `mode_o` shows one cycle later.
- R3: In fixed-priority mode (bit 0 clear), an idle arbiter grants the requesting channel with the largest priority value; `gnt_vld_o`/`gnt_ch_o` show it one cycle after the request, and the grant drops the cycle after `eng_done_i`.
- R4: In round-robin mode, an idle arbiter grants the first requesting channel found searching upward, wrapping past the top, from the channel after the last one granted; the first search after reset starts at channel 0.
- R5: `prio_err_o` is high one cycle after any two channel priorities are equal, and low one cycle after they are all distinct again.
- R6: While `prio_err_o` is high no new channel starts in fixed-priority mode, nor in round-robin mode when halt on error is set; round robin with halt on error clear still grants.
- R7: In fixed-priority mode with the engine not busy, a requester whose priority is strictly higher than the active channel's, whose can-preempt bit is set, takes the grant next cycle if the active channel's preemptable bit is set; `preempt_o` pulses high for exactly that cycle.
- R8: If either the active channel's preemptable bit or the requester's can-preempt bit is clear, the grant stays on the active channel.
- R9: Only one channel can be suspended; while one is, no further preemption occurs, and `eng_done_i` for the preempting channel moves the grant straight back to the suspended channel with `gnt_vld_o` staying high.
- R10: With continuous link on, `eng_done_i` together with `done_self_link_i` keeps the same channel granted without a gap, even when a higher-priority request is waiting; with continuous link off the grant drops.
- R11: With debug mode on and `dbg_stall_i` high, no channel starts and no preemption occurs, but the active channel keeps its grant until `eng_done_i`.
- R12: No preemption takes place in a cycle where `eng_busy_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 4 | New mode value |
| req_i | input | NCH | Channel request bits |
| prio_i | input | NCH x PRIO_W | Per-channel priority |
| preemptable_i | input | NCH | Channel may be suspended |
| can_preempt_i | input | NCH | Channel may suspend another |
| eng_busy_i | input | 1 | Engine is inside a bus access |
| eng_done_i | input | 1 | Active channel's minor loop finished |
| done_self_link_i | input | 1 | Finished minor loop links to its own channel |
| dbg_stall_i | input | 1 | Debug stall request |
| gnt_vld_o | output | 1 | A channel is granted |
| gnt_ch_o | output | IDX_W | Granted channel index |
| preempt_o | output | 1 | One-cycle strobe on a preemption |
| prio_err_o | output | 1 | Channel priorities are not unique |
| mode_o | output | 4 | Current mode |

## Verification
The hardest state to reach is a suspended channel coexisting with a second, even more urgent request, since it needs a running channel, a preempting channel and a third requester lined up in order with all permission bits set. The bench grants a low channel, then raises a higher one to force the suspension, then adds a top-priority request and holds it across several cycles before completing the minor loop, so that both the refusal of a second preemption and the gapless resume are observed. The denial cases are reached by toggling one permission bit or the busy input at a time while the same pair of requests stands.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // bit 0 round robin, bit 1 halt on error, bit 2 continuous link, bit 3 debug
    typedef struct packed {
        logic dbg;
        logic clink;
        logic halt;
        logic rr;
    } mode_t;

    localparam mode_t MODE_RESET = '{dbg: 1'b0, clink: 1'b0, halt: 1'b1, rr: 1'b0};

endpackage

// File: rtl/dma_arb_prio_pick.sv
// Picks the candidate with the largest priority value; ties go to the lowest index.
module dma_arb_prio_pick #(
    parameter int NCH    = 16,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]             cand_i,
    input  logic [NCH-1:0][PRIO_W-1:0] prio_i,
    output logic                       found_o,
    output logic [IDX_W-1:0]           idx_o
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cand_i[i] && (!found_o || (prio_i[i] > best))) begin
                found_o = 1'b1;
                best    = prio_i[i];
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
// Rotating search: first candidate above last_i, wrapping around.
module dma_arb_rr_pick #(
    parameter int NCH = 16,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]   cand_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    int pos;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        pos     = 0;
        for (int k = 1; k <= NCH; k++) begin
            pos = int'(last_i) + k;
            if (pos >= NCH) pos = pos - NCH;
            if (!found_o && cand_i[pos]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(pos);
            end
        end
    end
endmodule

// File: rtl/dma_arb_uniq_chk.sv
// Flags any pair of channels that share a priority value.
module dma_arb_uniq_chk #(
    parameter int NCH    = 16,
    parameter int PRIO_W = 4
) (
    input  logic [NCH-1:0][PRIO_W-1:0] prio_i,
    output logic                       dup_o
);
    logic [NCH*NCH-1:0] pair_eq;

    for (genvar a = 0; a < NCH; a++) begin : g_row
        for (genvar b = 0; b < NCH; b++) begin : g_col
            if (b > a) begin : g_cmp
                assign pair_eq[a*NCH+b] = (prio_i[a] == prio_i[b]);
            end else begin : g_none
                assign pair_eq[a*NCH+b] = 1'b0;
            end
        end
    end

    assign dup_o = |pair_eq;
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int PRIO_W = 4,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_we_i,
    input  logic [3:0]                 mode_wdata_i,
    input  logic [NCH-1:0]             req_i,
    input  logic [NCH-1:0][PRIO_W-1:0] prio_i,
    input  logic [NCH-1:0]             preemptable_i,
    input  logic [NCH-1:0]             can_preempt_i,
    input  logic                       eng_busy_i,
    input  logic                       eng_done_i,
    input  logic                       done_self_link_i,
    input  logic                       dbg_stall_i,
    output logic                       gnt_vld_o,
    output logic [IDX_W-1:0]           gnt_ch_o,
    output logic                       preempt_o,
    output logic                       prio_err_o,
    output logic [3:0]                 mode_o
);

    typedef struct packed {
        mode_t            mode;
        logic             act_vld;
        logic [IDX_W-1:0] act_ch;
        logic             sus_vld;
        logic [IDX_W-1:0] sus_ch;
        logic [IDX_W-1:0] last;
        logic             prio_err;
        logic             preempt;
    } state_t;

    state_t q, d;

    // ---------------- selection helpers ----------------
    logic             dup;
    logic             fx_found, rr_found, pre_found;
    logic [IDX_W-1:0] fx_idx, rr_idx, pre_idx;
    logic [NCH-1:0]   pre_cand;
    logic [PRIO_W-1:0] act_prio;

    dma_arb_uniq_chk #(.NCH(NCH), .PRIO_W(PRIO_W)) u_uniq (
        .prio_i (prio_i),
        .dup_o  (dup)
    );

    dma_arb_prio_pick #(.NCH(NCH), .PRIO_W(PRIO_W)) u_fixed (
        .cand_i  (req_i),
        .prio_i  (prio_i),
        .found_o (fx_found),
        .idx_o   (fx_idx)
    );

    dma_arb_rr_pick #(.NCH(NCH)) u_rr (
        .cand_i  (req_i),
        .last_i  (q.last),
        .found_o (rr_found),
        .idx_o   (rr_idx)
    );

    dma_arb_prio_pick #(.NCH(NCH), .PRIO_W(PRIO_W)) u_preempt (
        .cand_i  (pre_cand),
        .prio_i  (prio_i),
        .found_o (pre_found),
        .idx_o   (pre_idx)
    );

    assign act_prio = prio_i[q.act_ch];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            pre_cand[i] = req_i[i] && can_preempt_i[i]
                        && (IDX_W'(i) != q.act_ch)
                        && (prio_i[i] > act_prio);
        end
    end

    // ---------------- next state ----------------
    logic             stall_dbg;
    logic             err_block;
    logic             start_ok;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             preempt_ok;

    always_comb begin
        stall_dbg  = q.mode.dbg && dbg_stall_i;
        err_block  = q.prio_err && (!q.mode.rr || q.mode.halt);
        start_ok   = !stall_dbg && !err_block;
        pick_found = q.mode.rr ? rr_found : fx_found;
        pick_idx   = q.mode.rr ? rr_idx   : fx_idx;
        preempt_ok = q.act_vld && !q.sus_vld && !eng_busy_i && !eng_done_i
                   && !q.mode.rr && start_ok
                   && preemptable_i[q.act_ch] && pre_found;

        d          = q;
        d.preempt  = 1'b0;
        d.prio_err = dup;
        if (mode_we_i) d.mode = mode_t'(mode_wdata_i);

        if (q.act_vld) begin
            if (eng_done_i) begin
                if (q.mode.clink && done_self_link_i) begin
                    // self-linked channel continues without arbitration
                    d.act_ch = q.act_ch;
                end else if (q.sus_vld) begin
                    d.act_ch  = q.sus_ch;
                    d.sus_vld = 1'b0;
                end else begin
                    d.act_vld = 1'b0;
                end
            end else if (preempt_ok) begin
                d.sus_vld = 1'b1;
                d.sus_ch  = q.act_ch;
                d.act_ch  = pre_idx;
                d.last    = pre_idx;
                d.preempt = 1'b1;
            end
        end else if (start_ok && pick_found) begin
            d.act_vld = 1'b1;
            d.act_ch  = pick_idx;
            d.last    = pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode     <= MODE_RESET;
            q.act_vld  <= 1'b0;
            q.act_ch   <= '0;
            q.sus_vld  <= 1'b0;
            q.sus_ch   <= '0;
            q.last     <= IDX_W'(NCH - 1);
            q.prio_err <= 1'b0;
            q.preempt  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign gnt_vld_o  = q.act_vld;
    assign gnt_ch_o   = q.act_ch;
    assign preempt_o  = q.preempt;
    assign prio_err_o = q.prio_err;
    assign mode_o     = q.mode;

endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
    parameter int NCH = 16,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_we_i,
    input logic [3:0]       mode_wdata_i,
    input logic [NCH-1:0]   req_i,
    input logic [NCH-1:0]   preemptable_i,
    input logic [NCH-1:0]   can_preempt_i,
    input logic             eng_busy_i,
    input logic             eng_done_i,
    input logic             done_self_link_i,
    input logic             dbg_stall_i,
    input logic             gnt_vld_o,
    input logic [IDX_W-1:0] gnt_ch_o,
    input logic             preempt_o,
    input logic             prio_err_o,
    input logic [3:0]       mode_o
);
    logic [NCH-1:0]   req_q, pmt_q, canp_q;
    logic [IDX_W-1:0] gch_q;
    logic             gvld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            pmt_q  <= '0;
            canp_q <= '0;
            gch_q  <= '0;
            gvld_q <= 1'b0;
        end else begin
            req_q  <= req_i;
            pmt_q  <= preemptable_i;
            canp_q <= can_preempt_i;
            gch_q  <= gnt_ch_o;
            gvld_q <= gnt_vld_o;
        end
    end

    assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we_i |=> (mode_o == $past(mode_wdata_i)));

    assert_start_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_vld_o) |-> req_q[gnt_ch_o]);

    assert_error_blocks_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_err_o && (!mode_o[0] || mode_o[1]) && !gnt_vld_o) |=> !gnt_vld_o);

    assert_preempt_permitted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> (gvld_q && gnt_vld_o && canp_q[gnt_ch_o] && pmt_q[gch_q]));

    assert_self_link_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[2] && gnt_vld_o && eng_done_i && done_self_link_i)
        |=> (gnt_vld_o && $stable(gnt_ch_o)));

    assert_debug_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[3] && dbg_stall_i && !gnt_vld_o) |=> !gnt_vld_o);

    assert_debug_no_preempt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[3] && dbg_stall_i && gnt_vld_o && !eng_done_i) |=> $stable(gnt_ch_o));

    assert_busy_no_preempt_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld_o && eng_busy_i && !eng_done_i) |=> !preempt_o);

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode_we_i        (mode_we_i),
    .mode_wdata_i     (mode_wdata_i),
    .req_i            (req_i),
    .preemptable_i    (preemptable_i),
    .can_preempt_i    (can_preempt_i),
    .eng_busy_i       (eng_busy_i),
    .eng_done_i       (eng_done_i),
    .done_self_link_i (done_self_link_i),
    .dbg_stall_i      (dbg_stall_i),
    .gnt_vld_o        (gnt_vld_o),
    .gnt_ch_o         (gnt_ch_o),
    .preempt_o        (preempt_o),
    .prio_err_o       (prio_err_o),
    .mode_o           (mode_o)
);

// File: tb/tb_dma_chan_arbiter.sv
`timescale 1ns/1ps
module tb_dma_chan_arbiter;
    localparam int NCH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_we = 1'b0;
    logic [3:0]       mode_wdata = '0;
    logic [NCH-1:0]   req = '0;
    logic [NCH-1:0][3:0] prio;
    logic [NCH-1:0]   pmt = '0;
    logic [NCH-1:0]   canp = '0;
    logic             busy = 1'b0;
    logic             done = 1'b0;
    logic             self_lk = 1'b0;
    logic             stall = 1'b0;
    logic             gnt_vld;
    logic [3:0]       gnt_ch;
    logic             preempt;
    logic             prio_err;
    logic [3:0]       mode;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_chan_arbiter #(.NCH(NCH), .PRIO_W(4)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .mode_we_i        (mode_we),
        .mode_wdata_i     (mode_wdata),
        .req_i            (req),
        .prio_i           (prio),
        .preemptable_i    (pmt),
        .can_preempt_i    (canp),
        .eng_busy_i       (busy),
        .eng_done_i       (done),
        .done_self_link_i (self_lk),
        .dbg_stall_i      (stall),
        .gnt_vld_o        (gnt_vld),
        .gnt_ch_o         (gnt_ch),
        .preempt_o        (preempt),
        .prio_err_o       (prio_err),
        .mode_o           (mode)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_gnt(input bit vld, input int ch, input string tag);
        chk(gnt_vld == vld, {tag, " grant valid"}, int'(gnt_vld), int'(vld));
        if (vld) chk(int'(gnt_ch) == ch, {tag, " grant channel"}, int'(gnt_ch), ch);
    endtask

    task automatic set_mode(input logic [3:0] v);
        mode_we = 1'b1;
        mode_wdata = v;
        step();
        mode_we = 1'b0;
    endtask

    task automatic pulse_done();
        done = 1'b1;
        step();
        done = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        req = '0; pmt = '0; canp = '0; busy = 1'b0; done = 1'b0;
        self_lk = 1'b0; stall = 1'b0; mode_we = 1'b0;
        for (int i = 0; i < NCH; i++) prio[i] = 4'(i);
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        apply_reset();
        chk(gnt_vld == 1'b0, "R1 grant after reset", int'(gnt_vld), 0);
        chk(mode == 4'b0010, "R1 mode after reset", int'(mode), 2);
        chk(preempt == 1'b0, "R1 preempt after reset", int'(preempt), 0);
        chk(prio_err == 1'b0, "R1 prio error after reset", int'(prio_err), 0);
    endtask

    task automatic t_mode();
        set_mode(4'b0110);
        chk(mode == 4'b0110, "R2 mode write", int'(mode), 6);
        set_mode(4'b0010);
        chk(mode == 4'b0010, "R2 mode restore", int'(mode), 2);
    endtask

    task automatic t_fixed();
        apply_reset();
        req = (16'd1 << 3) | (16'd1 << 9) | (16'd1 << 5);
        step();
        chk_gnt(1'b1, 9, "R3 highest priority");
        req = '0;
        pulse_done();
        chk_gnt(1'b0, 0, "R3 drop after done");
        for (int i = 0; i < NCH; i++) prio[i] = 4'(15 - i);
        req = (16'd1 << 3) | (16'd1 << 9) | (16'd1 << 5);
        step();
        chk_gnt(1'b1, 3, "R3 reversed priorities");
        req = '0;
        pulse_done();
    endtask

    task automatic t_rr();
        int exp_seq[3] = '{7, 12, 2};
        apply_reset();
        set_mode(4'b0011);
        req = (16'd1 << 2) | (16'd1 << 7) | (16'd1 << 12);
        step();
        chk_gnt(1'b1, 2, "R4 first search from 0");
        for (int k = 0; k < 3; k++) begin
            pulse_done();
            chk_gnt(1'b0, 0, "R4 idle between grants");
            step();
            chk_gnt(1'b1, exp_seq[k], "R4 rotation");
        end
        req = '0;
        pulse_done();
    endtask

    task automatic t_err();
        apply_reset();
        prio[7] = 4'd4;
        step();
        chk(prio_err == 1'b1, "R5 duplicate flagged", int'(prio_err), 1);
        req = 16'd1 << 4;
        step(); step(); step();
        chk_gnt(1'b0, 0, "R6 fixed mode blocked");
        set_mode(4'b0011);
        step();
        chk_gnt(1'b0, 0, "R6 round robin with halt blocked");
        set_mode(4'b0001);
        step();
        chk_gnt(1'b1, 4, "R6 round robin without halt grants");
        req = '0;
        pulse_done();
        prio[7] = 4'd7;
        step();
        chk(prio_err == 1'b0, "R5 error clears", int'(prio_err), 0);
    endtask

    task automatic t_preempt();
        apply_reset();
        pmt = '1; canp = '1;
        req = 16'd1 << 2;
        step();
        chk_gnt(1'b1, 2, "R7 low channel running");
        req = 16'd1 << 10;
        step();
        chk_gnt(1'b1, 10, "R7 preempted by higher");
        chk(preempt == 1'b1, "R7 strobe", int'(preempt), 1);
        step();
        chk(preempt == 1'b0, "R7 strobe one cycle", int'(preempt), 0);
        req = (16'd1 << 10) | (16'd1 << 12);
        step(); step(); step();
        chk_gnt(1'b1, 10, "R9 no second preemption");
        chk(preempt == 1'b0, "R9 no second strobe", int'(preempt), 0);
        req = '0;
        pulse_done();
        chk_gnt(1'b1, 2, "R9 suspended channel resumes");
        pulse_done();
        chk_gnt(1'b0, 0, "R9 done after resume");
    endtask

    task automatic t_deny();
        apply_reset();
        pmt = '1; pmt[2] = 1'b0; canp = '1;
        req = 16'd1 << 2;
        step();
        chk_gnt(1'b1, 2, "R8 setup");
        req = 16'd1 << 10;
        step(); step();
        chk_gnt(1'b1, 2, "R8 not preemptable");
        pmt = '1; canp[10] = 1'b0;
        step(); step();
        chk_gnt(1'b1, 2, "R8 requester cannot preempt");
        canp = '1; busy = 1'b1;
        step(); step();
        chk_gnt(1'b1, 2, "R12 busy blocks preemption");
        busy = 1'b0;
        step();
        chk_gnt(1'b1, 10, "R7 preemption after busy clears");
        chk(preempt == 1'b1, "R7 strobe after busy", int'(preempt), 1);
        req = '0;
        pulse_done();
        pulse_done();
        chk_gnt(1'b0, 0, "R9 idle after both finish");
    endtask

    task automatic t_clink();
        apply_reset();
        set_mode(4'b0110);
        req = 16'd1 << 3;
        step();
        chk_gnt(1'b1, 3, "R10 setup");
        req = (16'd1 << 3) | (16'd1 << 14);
        done = 1'b1; self_lk = 1'b1;
        step();
        done = 1'b0; self_lk = 1'b0;
        chk_gnt(1'b1, 3, "R10 self link keeps channel");
        set_mode(4'b0010);
        done = 1'b1; self_lk = 1'b1;
        step();
        done = 1'b0; self_lk = 1'b0;
        chk_gnt(1'b0, 0, "R10 link off drops grant");
        step();
        chk_gnt(1'b1, 14, "R10 arbitration afterwards");
        req = '0;
        pulse_done();
    endtask

    task automatic t_debug();
        apply_reset();
        set_mode(4'b1010);
        stall = 1'b1;
        req = 16'd1 << 5;
        step(); step(); step();
        chk_gnt(1'b0, 0, "R11 stall blocks start");
        stall = 1'b0;
        step();
        chk_gnt(1'b1, 5, "R11 start after release");
        stall = 1'b1; pmt = '1; canp = '1;
        req = (16'd1 << 5) | (16'd1 << 9);
        step(); step();
        chk_gnt(1'b1, 5, "R11 active channel keeps running");
        chk(preempt == 1'b0, "R11 no preemption while stalled", int'(preempt), 0);
        req = 16'd1 << 9;
        pulse_done();
        chk_gnt(1'b0, 0, "R11 active channel completes");
        step(); step();
        chk_gnt(1'b0, 0, "R11 waiting request held off");
        stall = 1'b0;
        step();
        chk_gnt(1'b1, 9, "R11 waiting request starts");
        req = '0;
        pulse_done();
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) prio[i] = 4'(i);
        t_reset();
        t_mode();
        t_fixed();
        t_rr();
        t_err();
        t_preempt();
        t_deny();
        t_clink();
        t_debug();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule